// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which analog multiplexer input feeds each analog-to-digital conversion. Software programs a low and a high channel bound in one byte. The sequencer then steps a current-channel pointer through that range, one channel per conversion, and wraps back to the low bound after the high bound has been sampled. A conversion start comes from one of three places. It can be a software start pulse, a tick from an on-chip rate timer, or a falling edge on an external trigger pin. The external pin can be qualified by a gate pin.

Two timing behaviours protect the analog front end. Any change to the channel or input-range configuration opens a settling window, and conversions are refused while that window is open. In scan mode a single trigger walks the whole range from low to high, with a programmable spacing between samples, and busy stays asserted until the final sample has finished converting. Each conversion is announced by a one-cycle `conv_start` pulse. The `conv_chan` output carries the channel for that conversion. A status word reports busy, the input mode and the current channel.

Top module: `adc_chan_sequencer`

## Requirements
- R1: After reset, `cur_chan` is 0, `busy`, `settling` and `conv_start` are 0, and the status word shows channel 0 and single-ended mode.
- R2: A write to the channel register takes the high bound from bits 7:4 and the low bound from bits 3:0 of `chan_wdata`. From the next cycle on, `cur_chan` equals the low bound.
- R3: With scan mode off, each accepted trigger produces one `conv_start` pulse lasting one cycle. `conv_chan` carries the current channel during that pulse. The pointer then moves to the next channel, and it returns to the low bound once the high bound has been converted.
- R4: A channel-register write or an input-range write asserts `settling` from the next cycle for exactly SETTLE_CYC cycles (default 100).
- R5: A trigger that arrives while `busy` or `settling` is high is ignored: it produces no conversion and leaves the channel pointer unchanged.
- R6: A single conversion holds `busy` high for CONV_CYC cycles (default 40), starting in the cycle of its `conv_start` pulse.
- R7: With `scan_en` high, one trigger converts every channel from the low bound to the high bound in order. `busy` stays high until CONV_CYC cycles after the last sample starts, and the pointer then rests on the low bound.
- R8: Successive scan samples start GAP_SLOW_CYC cycles apart (default 93) when `fast_gap` is 0, and GAP_FAST_CYC cycles apart (default 53) when it is 1.
- R9: With `hw_clk_en` low, only `sw_start` triggers. With `hw_clk_en` high, `sw_start` is ignored. In that case `hw_src_int`=1 selects `timer_tick` as the trigger, and `hw_src_int`=0 selects falling edges of `ext_trig`.
- R10: With `gate_en` high, a falling edge of `ext_trig` triggers only while `gate_in` is high. A rising edge of `ext_trig` never triggers.
- R11: A high bound below the low bound is treated as equal to the low bound.
- R12: With `diff_mode` high, only the lower three bits of each bound are used. Status bit 5 is 1 in single-ended mode and 0 in differential mode.
- R13: Status bit 7 mirrors `busy`, and status bits 3:0 mirror `cur_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_wr | input | 1 | Write strobe for the channel-bound register |
| chan_wdata | input | 8 | High bound [7:4], low bound [3:0] |
| range_wr | input | 1 | Strobe marking a write to the input-range setting |
| sw_start | input | 1 | Software conversion start pulse |
| hw_clk_en | input | 1 | 1 = hardware trigger source, 0 = software start |
| hw_src_int | input | 1 | Hardware source: 1 = rate timer, 0 = external pin |
| timer_tick | input | 1 | Pulse from the rate timer |
| ext_trig | input | 1 | External trigger pin, active on falling edges |
| gate_en | input | 1 | Enables gating of the external trigger |
| gate_in | input | 1 | Gate pin, high allows external triggers |
| scan_en | input | 1 | 1 = one trigger runs the whole range |
| fast_gap | input | 1 | Scan spacing select: 0 = long, 1 = short |
| diff_mode | input | 1 | 1 = differential inputs (8 channels) |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 4 | Channel for the conversion being started |
| cur_chan | output | 4 | Channel pointer for the next conversion |
| busy | output | 1 | Conversion or scan in progress |
| settling | output | 1 | Settling window open, conversions blocked |
| status_word | output | 8 | busy [7], single-ended [5], current channel [3:0] |

## Verification
The embedded properties assume that `chan_wr`, `range_wr`, `sw_start` and `timer_tick` are single-cycle strobes. They also assume that `diff_mode` does not change in the cycle that follows a channel write. The settle and start properties further assume that no channel write lands during a scan, since such a write would move the pointer under a running sequence. The stimulus follows these assumptions. It drives every strobe for exactly one clock, and it changes mode and scan inputs only while the block is idle and out of its settling window. It issues configuration writes only after `busy` has dropped, except in the deliberate cases where a start is aimed at the busy or settling window to show that it is refused.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_GAP  = 2'd1,
      SEQ_CONV = 2'd2
   } seq_state_e;

   localparam int STAT_BUSY_OFS = 3;
   localparam int STAT_SE_OFS   = 1;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             active,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign active = (cnt_q != '0);
   assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/seq_trig_sel.sv
module seq_trig_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_start,
   input  logic hw_clk_en,
   input  logic hw_src_int,
   input  logic timer_tick,
   input  logic ext_trig,
   input  logic gate_en,
   input  logic gate_in,
   output logic trig
);

   logic ext_s;
   logic gate_s;
   logic ext_prev_q;
   logic ext_fall;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ext_s  = ext_trig;
         assign gate_s = gate_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] ext_pipe_q;
         logic [SYNC_STAGES-1:0] gate_pipe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ext_pipe_q  <= '1;
               gate_pipe_q <= '0;
            end else begin
               ext_pipe_q  <= SYNC_STAGES'({ext_pipe_q, ext_trig});
               gate_pipe_q <= SYNC_STAGES'({gate_pipe_q, gate_in});
            end
         end
         assign ext_s  = ext_pipe_q[SYNC_STAGES-1];
         assign gate_s = gate_pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ext_prev_q <= 1'b1;
      else        ext_prev_q <= ext_s;
   end

   assign ext_fall = ext_prev_q & ~ext_s;

   always_comb begin
      if (!hw_clk_en)      trig = sw_start;
      else if (hw_src_int) trig = timer_tick;
      else                 trig = ext_fall & (~gate_en | gate_s);
   end

   // R10: a rising edge on the synchronized pin never yields an external trigger
   assert_no_rise_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clk_en && !hw_src_int && !ext_prev_q && ext_s) |-> !trig);

endmodule

// File: rtl/seq_chan_ctr.sv
module seq_chan_ctr #(
   parameter int CHAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2*CHAN_W-1:0] wr_data,
   input  logic              diff_mode,
   input  logic              adv,
   input  logic              use_low,
   output logic [CHAN_W-1:0] cur_chan,
   output logic [CHAN_W-1:0] sample_chan,
   output logic              sample_last
);

   localparam logic [CHAN_W-1:0] DIFF_MASK = {1'b0, {(CHAN_W-1){1'b1}}};

   logic [CHAN_W-1:0] lo_q, hi_q, cur_q;
   logic [CHAN_W-1:0] mask_v, lo_m, hi_m, hi_eff, wr_lo_m;

   assign mask_v  = diff_mode ? DIFF_MASK : '1;
   assign lo_m    = lo_q & mask_v;
   assign hi_m    = hi_q & mask_v;
   assign hi_eff  = (hi_m < lo_m) ? lo_m : hi_m;
   assign wr_lo_m = wr_data[CHAN_W-1:0] & mask_v;

   assign sample_chan = use_low ? lo_m : (cur_q & mask_v);
   assign sample_last = (sample_chan >= hi_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         cur_q <= '0;
      end else if (wr_en) begin
         lo_q  <= wr_data[CHAN_W-1:0];
         hi_q  <= wr_data[2*CHAN_W-1:CHAN_W];
         cur_q <= wr_lo_m;
      end else if (adv) begin
         cur_q <= sample_last ? lo_m : sample_chan + CHAN_W'(1);
      end
   end

   assign cur_chan = cur_q;

   // R2: a register write moves the pointer to the written low bound
   assert_reload_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cur_chan == ($past(wr_data[CHAN_W-1:0]) & mask_v));

   // R3: converting the high bound brings the pointer back to the low bound
   assert_wrap_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && sample_last && !wr_en) |=> cur_chan == lo_m);

endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer
   import adc_seq_pkg::*;
#(
   parameter int CHAN_W       = 4,
   parameter int SETTLE_CYC   = 100,
   parameter int CONV_CYC     = 40,
   parameter int GAP_SLOW_CYC = 93,
   parameter int GAP_FAST_CYC = 53,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chan_wr,
   input  logic [2*CHAN_W-1:0] chan_wdata,
   input  logic                range_wr,
   input  logic                sw_start,
   input  logic                hw_clk_en,
   input  logic                hw_src_int,
   input  logic                timer_tick,
   input  logic                ext_trig,
   input  logic                gate_en,
   input  logic                gate_in,
   input  logic                scan_en,
   input  logic                fast_gap,
   input  logic                diff_mode,
   output logic                conv_start,
   output logic [CHAN_W-1:0]   conv_chan,
   output logic [CHAN_W-1:0]   cur_chan,
   output logic                busy,
   output logic                settling,
   output logic [CHAN_W+3:0]   status_word
);

   localparam int MAX_A   = (SETTLE_CYC > CONV_CYC) ? SETTLE_CYC : CONV_CYC;
   localparam int MAX_B   = (GAP_SLOW_CYC > GAP_FAST_CYC) ? GAP_SLOW_CYC : GAP_FAST_CYC;
   localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TMR_W   = $clog2(MAX_CYC + 1);

   generate
      if (CHAN_W < 2 || SETTLE_CYC < 1 || CONV_CYC < 1 ||
          GAP_SLOW_CYC < 2 || GAP_FAST_CYC < 2 || SYNC_STAGES < 0) begin : g_param_check
         $error("adc_chan_sequencer: parameter out of range");
      end
   endgenerate

   seq_state_e        state_q;
   logic              scan_run_q;
   logic              conv_start_q;
   logic [CHAN_W-1:0] conv_chan_q;

   logic              trig, accept, step, scan_mode, go_gap;
   logic [CHAN_W-1:0] sample_chan;
   logic              sample_last;
   logic              settle_act, settle_exp;
   logic              phase_act, phase_exp;
   logic [TMR_W-1:0]  gap_len, phase_val;

   seq_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_start   (sw_start),
      .hw_clk_en  (hw_clk_en),
      .hw_src_int (hw_src_int),
      .timer_tick (timer_tick),
      .ext_trig   (ext_trig),
      .gate_en    (gate_en),
      .gate_in    (gate_in),
      .trig       (trig)
   );

   assign accept    = trig && (state_q == SEQ_IDLE) && !settle_act;
   assign step      = accept || ((state_q == SEQ_GAP) && phase_exp);
   assign scan_mode = (state_q == SEQ_IDLE) ? scan_en : scan_run_q;
   assign go_gap    = scan_mode && !sample_last;
   assign gap_len   = fast_gap ? TMR_W'(GAP_FAST_CYC) : TMR_W'(GAP_SLOW_CYC);
   assign phase_val = go_gap ? gap_len : TMR_W'(CONV_CYC);

   seq_chan_ctr #(.CHAN_W(CHAN_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (chan_wr),
      .wr_data     (chan_wdata),
      .diff_mode   (diff_mode),
      .adv         (step),
      .use_low     (accept && scan_en),
      .cur_chan    (cur_chan),
      .sample_chan (sample_chan),
      .sample_last (sample_last)
   );

   seq_timer #(.CNT_W(TMR_W)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (chan_wr | range_wr),
      .load_val (TMR_W'(SETTLE_CYC)),
      .active   (settle_act),
      .expire   (settle_exp)
   );

   seq_timer #(.CNT_W(TMR_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (step),
      .load_val (phase_val),
      .active   (phase_act),
      .expire   (phase_exp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= SEQ_IDLE;
         scan_run_q   <= 1'b0;
         conv_start_q <= 1'b0;
         conv_chan_q  <= '0;
      end else begin
         conv_start_q <= step;
         if (step) begin
            conv_chan_q <= sample_chan;
            state_q     <= go_gap ? SEQ_GAP : SEQ_CONV;
            if (accept) scan_run_q <= scan_en;
         end else if ((state_q == SEQ_CONV) && phase_exp) begin
            state_q <= SEQ_IDLE;
         end
      end
   end

   assign conv_start  = conv_start_q;
   assign conv_chan   = conv_chan_q;
   assign busy        = (state_q != SEQ_IDLE);
   assign settling    = settle_act;
   assign status_word = {busy, 1'b0, ~diff_mode, 1'b0, cur_chan};

   // R4: any configuration write opens the settling window on the next cycle
   assert_settle_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_wr || range_wr) |=> settling);

   // R4: the window closes once its count runs out, unless reopened
   assert_settle_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (settle_exp && !chan_wr && !range_wr) |=> !settling);

   // R5: from idle, no conversion may start while the input is settling
   assert_no_start_settling_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && settling) |=> !conv_start);

   // R6: every start pulse falls inside a busy period
   assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   // R6: the phase timer only runs while a conversion or scan is active
   assert_phase_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_IDLE) |-> !phase_act);

   // R9: with the timer source selected, no tick means no new conversion from idle
   assert_sw_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clk_en && hw_src_int && !timer_tick && !busy) |=> !conv_start);

endmodule

// File: tb/test_adc_chan_sequencer.sv
module test_adc_chan_sequencer;

   localparam int CLK_PERIOD = 100;
   localparam int SETTLE = 100;
   localparam int CONV   = 40;
   localparam int GSLOW  = 93;
   localparam int GFAST  = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_wr = 1'b0;
   logic [7:0] chan_wdata = 8'h00;
   logic       range_wr = 1'b0;
   logic       sw_start = 1'b0;
   logic       hw_clk_en = 1'b0;
   logic       hw_src_int = 1'b0;
   logic       timer_tick = 1'b0;
   logic       ext_trig = 1'b1;
   logic       gate_en = 1'b0;
   logic       gate_in = 1'b0;
   logic       scan_en = 1'b0;
   logic       fast_gap = 1'b0;
   logic       diff_mode = 1'b0;
   logic       conv_start;
   logic [3:0] conv_chan;
   logic [3:0] cur_chan;
   logic       busy;
   logic       settling;
   logic [7:0] status_word;

   adc_chan_sequencer i_adc_chan_sequencer (
      .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr), .chan_wdata(chan_wdata),
      .range_wr(range_wr), .sw_start(sw_start), .hw_clk_en(hw_clk_en),
      .hw_src_int(hw_src_int), .timer_tick(timer_tick), .ext_trig(ext_trig),
      .gate_en(gate_en), .gate_in(gate_in), .scan_en(scan_en), .fast_gap(fast_gap),
      .diff_mode(diff_mode), .conv_start(conv_start), .conv_chan(conv_chan),
      .cur_chan(cur_chan), .busy(busy), .settling(settling), .status_word(status_word)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int    chan;
      int    gap;
      string req;
   } exp_t;

   exp_t  exp_q[$];
   int    total = 0;
   int    bad = 0;
   int    cyc = 0;
   int    conv_count = 0;
   int    last_cyc = 0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // monitor: pops expected conversions and compares channel and spacing
   always @(negedge clk) begin
      if (rst_n && conv_start) begin
         conv_count++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected conversion", int'(conv_chan), -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(int'(conv_chan) == e.chan, e.req, int'(conv_chan), e.chan);
            if (e.gap != 0)
               check((cyc - last_cyc) == e.gap, "R8 sample spacing", cyc - last_cyc, e.gap);
         end
         last_cyc = cyc;
      end
   end

   task automatic expect_conv(input int ch, input int gap, input string req);
      exp_t e;
      e.chan = ch; e.gap = gap; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_chan(input logic [7:0] v);
      chan_wdata = v; chan_wr = 1'b1;
      @(negedge clk);
      chan_wr = 1'b0;
   endtask

   task automatic pulse_sw();
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy || settling) @(negedge clk);
      tick(2);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   initial begin
      int n;
      int base;
      tick(4);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state, R13 status layout
      check(cur_chan == 4'd0, "R1 cur_chan after reset", cur_chan, 0);
      check(!busy && !settling && !conv_start, "R1 idle after reset",
            {busy, settling, conv_start}, 0);
      check(status_word == 8'h20, "R13 status after reset", status_word, 8'h20);

      // R2 channel write, R4 settle length
      write_chan(8'h52);
      check(cur_chan == 4'd2, "R2 pointer loads low bound", cur_chan, 2);
      n = 0;
      while (settling) begin n++; @(negedge clk); end
      check(n == SETTLE, "R4 settle window length", n, SETTLE);
      tick(2);

      // R3 single conversions with wrap, R6 busy length
      expect_conv(2, 0, "R3 single chan");
      pulse_sw();
      check(status_word[7] == 1'b1, "R13 status busy bit", status_word[7], 1);
      count_busy(n);
      check(n == CONV, "R6 single busy length", n, CONV);
      wait_idle();
      expect_conv(3, 0, "R3 single chan"); pulse_sw(); wait_idle();
      expect_conv(4, 0, "R3 single chan"); pulse_sw(); wait_idle();
      expect_conv(5, 0, "R3 single chan"); pulse_sw(); wait_idle();
      expect_conv(2, 0, "R3 wrap to low"); pulse_sw(); wait_idle();
      check(cur_chan == 4'd3, "R3 pointer after wrap", cur_chan, 3);

      // R5 start while busy ignored
      base = conv_count;
      expect_conv(3, 0, "R5 first start");
      pulse_sw(); tick(5); pulse_sw();
      wait_idle();
      check(conv_count - base == 1, "R5 busy start ignored", conv_count - base, 1);
      check(cur_chan == 4'd4, "R5 pointer after busy start", cur_chan, 4);

      // R4 range write settles, R5 start while settling ignored
      base = conv_count;
      range_wr = 1'b1; @(negedge clk); range_wr = 1'b0;
      check(settling == 1'b1, "R4 range write settles", settling, 1);
      pulse_sw();
      wait_idle();
      check(conv_count == base, "R5 settling start ignored", conv_count - base, 0);
      check(cur_chan == 4'd4, "R5 pointer kept while settling", cur_chan, 4);

      // R11 high below low
      write_chan(8'h36);
      wait_idle();
      expect_conv(6, 0, "R11 inverted bounds"); pulse_sw(); wait_idle();
      expect_conv(6, 0, "R11 inverted bounds"); pulse_sw(); wait_idle();
      check(cur_chan == 4'd6, "R11 pointer stays on low", cur_chan, 6);

      // R7, R8 scan with long spacing
      write_chan(8'h41);
      wait_idle();
      scan_en = 1'b1; fast_gap = 1'b0;
      expect_conv(1, 0, "R7 scan chan");
      expect_conv(2, GSLOW, "R7 scan chan");
      expect_conv(3, GSLOW, "R7 scan chan");
      expect_conv(4, GSLOW, "R7 scan chan");
      pulse_sw();
      count_busy(n);
      check(n == 3*GSLOW + CONV, "R7 scan busy length", n, 3*GSLOW + CONV);
      wait_idle();
      check(cur_chan == 4'd1, "R7 pointer after scan", cur_chan, 1);

      // R8 short spacing
      fast_gap = 1'b1;
      expect_conv(1, 0, "R8 scan chan");
      expect_conv(2, GFAST, "R8 scan chan");
      expect_conv(3, GFAST, "R8 scan chan");
      expect_conv(4, GFAST, "R8 scan chan");
      pulse_sw();
      count_busy(n);
      check(n == 3*GFAST + CONV, "R8 fast scan busy length", n, 3*GFAST + CONV);
      wait_idle();
      scan_en = 1'b0;

      // R9 hardware timer source, software start ignored
      hw_clk_en = 1'b1; hw_src_int = 1'b1;
      base = conv_count;
      pulse_sw(); tick(4);
      check(conv_count == base, "R9 sw start ignored in hw mode", conv_count - base, 0);
      expect_conv(1, 0, "R9 timer tick start");
      timer_tick = 1'b1; @(negedge clk); timer_tick = 1'b0;
      wait_idle();
      check(conv_count - base == 1, "R9 timer tick converts", conv_count - base, 1);

      // R10 gated external trigger
      hw_src_int = 1'b0; gate_en = 1'b1; gate_in = 1'b0;
      tick(5);
      base = conv_count;
      ext_trig = 1'b0; tick(8); ext_trig = 1'b1; tick(8);
      check(conv_count == base, "R10 gate low blocks", conv_count - base, 0);
      gate_in = 1'b1; tick(5);
      expect_conv(2, 0, "R10 gated fall");
      ext_trig = 1'b0; tick(8); wait_idle();
      check(conv_count - base == 1, "R10 gate high passes", conv_count - base, 1);
      ext_trig = 1'b1; tick(10);
      check(conv_count - base == 1, "R10 rising edge ignored", conv_count - base, 1);
      gate_en = 1'b0; gate_in = 1'b0; tick(5);
      expect_conv(3, 0, "R9 ungated external fall");
      ext_trig = 1'b0; tick(8); wait_idle();
      check(conv_count - base == 2, "R9 external fall converts", conv_count - base, 2);
      ext_trig = 1'b1; tick(5);
      hw_clk_en = 1'b0;

      // R12 differential mode masks bounds and flips status bit
      diff_mode = 1'b1; tick(2);
      write_chan(8'hF9);
      check(cur_chan == 4'd1, "R12 low bound masked", cur_chan, 1);
      check(status_word[5] == 1'b0, "R12 status mode bit", status_word[5], 0);
      wait_idle();
      expect_conv(1, 0, "R12 diff chan"); pulse_sw(); wait_idle();
      check(cur_chan == 4'd2, "R12 pointer advance", cur_chan, 2);

      tick(5);
      check(exp_q.size() == 0, "R3 all expected conversions seen", exp_q.size(), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule